// File: doc/BRIEF.md
# 32-bit Quad Register Data Unit

This block executes 32-bit data operations on a register Q that has no storage of its own. Q is the concatenation of four 8-bit CPU registers. The CPU presents the four register values, a prefixed opcode, a 32-bit memory operand and the carry flag, and pulses `op_valid`. One clock later the block returns three things:

- the new values of the four registers, with a write enable;
- a 32-bit word for memory write-back, with its own write enable;
- the N, Z, C and V flags, with a per-flag update mask.

Address generation and bus sequencing stay with the CPU. The unit decides only what is computed and where it goes.

There are three groups of operations:

- Register-form operations combine Q with the memory word or replace Q: OR, AND, XOR, add, subtract and load.
- Unary operations work on the full 32 bits of Q: shift, rotate, increment and decrement.
- Memory read-modify-write operations apply the same unary functions to the memory word and leave the four registers alone.

Compare only updates flags. Store writes Q to memory and still updates N and Z.

Top module: `quad_reg_unit`

## Requirements
- R1: Q is assembled as {z_in, y_in, x_in, a_in}, so `a` holds bits 7:0 and `z` holds bits 31:24. Results are split back the same way: `a_out` gets bits 7:0 and `z_out` gets bits 31:24.
- R2: Outputs are registered and appear exactly one clock after an `op_valid` cycle, with `done` high for that one cycle.
  - After a cycle without `op_valid`, these outputs are all 0: `done`, `reg_we`, `mem_we`, `flag_we` and `mem_out`.
  - When `reg_we` is 0, the register outputs carry the unchanged input Q.
- R3: Opcode bits 7:5 select the binary class for all opcodes not claimed by R9, R10 or R11: 0 OR, 1 AND, 2 XOR, 3 add, 4 store, 5 load, 6 compare, 7 subtract. OR, AND and XOR write Q op M to the registers and update only N and Z.
- R4: Add writes Q+M+C. C is the carry out of bit 31 and V is the signed overflow. All four flags are updated.
- R5: Subtract writes Q-M-(1-C). C is set when no borrow occurs and V is the signed overflow. All four flags are updated.
- R6: Compare forms Q-M and sets C when Q >= M as unsigned values. It updates N, Z and C only, and writes neither the registers nor memory.
- R7: Load writes M to Q and updates N and Z.
- R8: Store drives Q on `mem_out` with `mem_we`, writes no register, and updates N and Z from Q.
- R9: Opcodes 0x0A, 0x2A, 0x4A and 0x6A shift Q left, rotate Q left through C, shift Q right and rotate Q right through C. The bit shifted out goes to C. N, Z and C are updated and the result goes to the registers.
- R10: Opcodes below 0x80 with low nibble A and bit 4 set increment Q (bit 5 clear, e.g. 0x1A) or decrement Q (bit 5 set, e.g. 0x3A). The result goes to the registers and only N and Z are updated.
- R11: Opcodes with bits 2:0 = 110 in classes 0, 1, 2, 3, 6 and 7 are memory read-modify-write operations on M: shift left, rotate left, shift right, rotate right, decrement and increment respectively.
  - The result goes to `mem_out` with `mem_we`, and `reg_we` stays 0.
  - Flags follow R9 and R10.
- R12: N is bit 31 of the result and Z is set only when all 32 result bits are zero. The flag mask `flag_we` is ordered {N, Z, C, V} from bit 3 down to bit 0.
- R13: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| opcode | input | 8 | Opcode byte following the quad prefix |
| a_in | input | 8 | Register A, Q bits 7:0 |
| x_in | input | 8 | Register X, Q bits 15:8 |
| y_in | input | 8 | Register Y, Q bits 23:16 |
| z_in | input | 8 | Register Z, Q bits 31:24 |
| mem_in | input | 32 | Memory operand M |
| carry_in | input | 1 | Current carry flag |
| done | output | 1 | Result valid |
| a_out | output | 8 | New A |
| x_out | output | 8 | New X |
| y_out | output | 8 | New Y |
| z_out | output | 8 | New Z |
| reg_we | output | 1 | Write the four registers |
| mem_out | output | 32 | Memory write-back data |
| mem_we | output | 1 | Write memory |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_we | output | 4 | Flag update mask {N,Z,C,V} |

## Verification
The assertions check several properties on every cycle:
- the one-cycle latency and the quiet outputs of an idle cycle;
- that register and memory writes never occur together;
- that N always matches bit 31 of whichever result is written;
- that Z matches an all-zero register result.

Whether a value is arithmetically right can only be shown by the bench. This covers carry and overflow at the signed and unsigned boundaries, the rotate carry paths and the opcode-to-operation map. The bench sweeps every opcode against operand pairs at those boundaries with both carry values.

// File: rtl/qru_pkg.sv
package qru_pkg;
    typedef enum logic [3:0] {
        QOP_OR, QOP_AND, QOP_XOR, QOP_ADD, QOP_SUB, QOP_CMP, QOP_LD, QOP_ST,
        QOP_ASL, QOP_ROL, QOP_LSR, QOP_ROR, QOP_INC, QOP_DEC
    } qop_e;

    // flag mask bit order {N, Z, C, V}
    localparam logic [3:0] FM_NZ   = 4'b1100;
    localparam logic [3:0] FM_NZC  = 4'b1110;
    localparam logic [3:0] FM_NZCV = 4'b1111;

    typedef struct packed {
        qop_e       op;
        logic       src_mem;   // unary op works on memory word
        logic       wr_reg;
        logic       wr_mem;
        logic [3:0] fmask;
    } qdec_t;
endpackage

// File: rtl/qru_decode.sv
module qru_decode
    import qru_pkg::*;
(
    input  logic [7:0] opcode,
    output qdec_t      dec
);
    logic [2:0] cls;
    assign cls = opcode[7:5];

    always_comb begin
        dec = '{op: QOP_OR, src_mem: 1'b0, wr_reg: 1'b0, wr_mem: 1'b0, fmask: FM_NZ};
        if (!opcode[7] && opcode[3:0] == 4'hA) begin
            dec.wr_reg = 1'b1;
            if (!opcode[4]) begin
                dec.fmask = FM_NZC;
                case (opcode[6:5])
                    2'd0:    dec.op = QOP_ASL;
                    2'd1:    dec.op = QOP_ROL;
                    2'd2:    dec.op = QOP_LSR;
                    default: dec.op = QOP_ROR;
                endcase
            end else begin
                dec.op = opcode[5] ? QOP_DEC : QOP_INC;
            end
        end else if (opcode[2:0] == 3'b110 && cls != 3'd4 && cls != 3'd5) begin
            dec.src_mem = 1'b1;
            dec.wr_mem  = 1'b1;
            dec.fmask   = cls[2] ? FM_NZ : FM_NZC;
            case (cls)
                3'd0:    dec.op = QOP_ASL;
                3'd1:    dec.op = QOP_ROL;
                3'd2:    dec.op = QOP_LSR;
                3'd3:    dec.op = QOP_ROR;
                3'd6:    dec.op = QOP_DEC;
                default: dec.op = QOP_INC;
            endcase
        end else begin
            case (cls)
                3'd0: begin dec.op = QOP_OR;  dec.wr_reg = 1'b1; end
                3'd1: begin dec.op = QOP_AND; dec.wr_reg = 1'b1; end
                3'd2: begin dec.op = QOP_XOR; dec.wr_reg = 1'b1; end
                3'd3: begin dec.op = QOP_ADD; dec.wr_reg = 1'b1; dec.fmask = FM_NZCV; end
                3'd4: begin dec.op = QOP_ST;  dec.wr_mem = 1'b1; end
                3'd5: begin dec.op = QOP_LD;  dec.wr_reg = 1'b1; end
                3'd6: begin dec.op = QOP_CMP; dec.fmask = FM_NZC; end
                default: begin dec.op = QOP_SUB; dec.wr_reg = 1'b1; dec.fmask = FM_NZCV; end
            endcase
        end
    end
endmodule

// File: rtl/qru_alu.sv
module qru_alu
    import qru_pkg::*;
#(
    parameter int W = 32
) (
    input  qop_e         op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         vout
);
    logic         is_sub;
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   sum;

    always_comb begin
        is_sub = (op == QOP_SUB) || (op == QOP_CMP);
        b_eff  = is_sub ? ~opb : opb;
        c_eff  = (op == QOP_CMP) ? 1'b1 : cin;
        sum    = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    end

    always_comb begin
        res  = '0;
        cout = cin;
        vout = 1'b0;
        unique case (op)
            QOP_OR:  res = opa | opb;
            QOP_AND: res = opa & opb;
            QOP_XOR: res = opa ^ opb;
            QOP_ADD, QOP_SUB, QOP_CMP: begin
                res  = sum[W-1:0];
                cout = sum[W];
                vout = (opa[W-1] == b_eff[W-1]) && (sum[W-1] != opa[W-1]);
            end
            QOP_LD:  res = opb;
            QOP_ST:  res = opa;
            QOP_ASL: {cout, res} = {opa, 1'b0};
            QOP_ROL: {cout, res} = {opa, cin};
            QOP_LSR: {res, cout} = {1'b0, opa};
            QOP_ROR: {res, cout} = {cin, opa};
            QOP_INC: res = opa + {{(W-1){1'b0}}, 1'b1};
            QOP_DEC: res = opa - {{(W-1){1'b0}}, 1'b1};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/quad_reg_unit.sv
module quad_reg_unit
    import qru_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] x_in,
    input  logic [LANE_W-1:0] y_in,
    input  logic [LANE_W-1:0] z_in,
    input  logic [4*LANE_W-1:0] mem_in,
    input  logic              carry_in,
    output logic              done,
    output logic [LANE_W-1:0] a_out,
    output logic [LANE_W-1:0] x_out,
    output logic [LANE_W-1:0] y_out,
    output logic [LANE_W-1:0] z_out,
    output logic              reg_we,
    output logic [4*LANE_W-1:0] mem_out,
    output logic              mem_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic [3:0]        flag_we
);
    localparam int LANES = 4;
    localparam int QW    = LANES * LANE_W;

    typedef struct packed {
        logic          done;
        logic [QW-1:0] q;
        logic          reg_we;
        logic [QW-1:0] mem;
        logic          mem_we;
        logic [3:0]    flags;   // {N, Z, C, V}
        logic [3:0]    fwe;
    } state_t;

    state_t st_d, st_q;

    logic [LANE_W-1:0] lane_in  [LANES];
    logic [QW-1:0]     q_in;

    assign lane_in[0] = a_in;
    assign lane_in[1] = x_in;
    assign lane_in[2] = y_in;
    assign lane_in[3] = z_in;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign q_in[g*LANE_W +: LANE_W] = lane_in[g];
    end

    qdec_t         dec;
    logic [QW-1:0] alu_a, alu_res;
    logic          alu_c, alu_v;

    qru_decode u_dec (.opcode(opcode), .dec(dec));

    assign alu_a = dec.src_mem ? mem_in : q_in;

    qru_alu #(.W(QW)) u_alu (
        .op(dec.op), .opa(alu_a), .opb(mem_in), .cin(carry_in),
        .res(alu_res), .cout(alu_c), .vout(alu_v)
    );

    always_comb begin
        st_d        = '0;
        st_d.q      = q_in;
        if (op_valid) begin
            st_d.done   = 1'b1;
            st_d.reg_we = dec.wr_reg;
            st_d.mem_we = dec.wr_mem;
            st_d.fwe    = dec.fmask;
            if (dec.wr_reg) st_d.q   = alu_res;
            if (dec.wr_mem) st_d.mem = alu_res;
            st_d.flags  = {alu_res[QW-1], alu_res == '0, alu_c, alu_v} & dec.fmask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done    = st_q.done;
    assign a_out   = rst_n ? st_q.q[0*LANE_W +: LANE_W] : '0;
    assign x_out   = rst_n ? st_q.q[1*LANE_W +: LANE_W] : '0;
    assign y_out   = rst_n ? st_q.q[2*LANE_W +: LANE_W] : '0;
    assign z_out   = rst_n ? st_q.q[3*LANE_W +: LANE_W] : '0;
    assign reg_we  = st_q.reg_we;
    assign mem_out = st_q.mem;
    assign mem_we  = st_q.mem_we;
    assign flag_n  = st_q.flags[3];
    assign flag_z  = st_q.flags[2];
    assign flag_c  = st_q.flags[1];
    assign flag_v  = st_q.flags[0];
    assign flag_we = st_q.fwe;

    // R2: a started operation reports one clock later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);
    // R2: idle cycle leaves every enable low
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!done && !reg_we && !mem_we && flag_we == 4'b0000));
    // R6/R8/R11: a result goes to one destination at most
    p_one_dest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && mem_we));
    // R12: N mirrors bit 31 of a register result
    p_n_reg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reg_we && flag_we[3]) |-> (flag_n == z_out[LANE_W-1]));
    // R12: N mirrors bit 31 of a memory result
    p_n_mem_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mem_we) |-> (flag_we[3] && flag_n == mem_out[QW-1]));
    // R12: Z set exactly when the register result is zero
    p_z_reg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reg_we) |-> (flag_z == ({z_out, y_out, x_out, a_out} == '0)));
endmodule

// File: tb/sim_quad_reg_unit.sv
`timescale 1ns/1ps
module sim_quad_reg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  a_in = '0, x_in = '0, y_in = '0, z_in = '0;
    logic [31:0] mem_in = '0;
    logic        carry_in = 1'b0;
    logic        done, reg_we, mem_we, flag_n, flag_z, flag_c, flag_v;
    logic [7:0]  a_out, x_out, y_out, z_out;
    logic [31:0] mem_out;
    logic [3:0]  flag_we;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    quad_reg_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .a_in(a_in), .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .mem_in(mem_in), .carry_in(carry_in), .done(done),
        .a_out(a_out), .x_out(x_out), .y_out(y_out), .z_out(z_out),
        .reg_we(reg_we), .mem_out(mem_out), .mem_we(mem_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .flag_we(flag_we)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected result from the requirement text
    task automatic model(input logic [7:0] op, input logic [31:0] q, input logic [31:0] m,
                         input logic cin, output logic [127:0] bundle, output string tag);
        logic [31:0] res;
        logic        c, v, wr_r, wr_m;
        logic [3:0]  fm;
        longint      us, ss;
        res = 0; c = 0; v = 0; wr_r = 0; wr_m = 0; fm = 4'b1100; tag = "R3";
        if (!op[7] && op[3:0] == 4'hA) begin
            wr_r = 1;
            if (!op[4]) begin
                fm = 4'b1110; tag = "R9";
                case (op[6:5])
                    2'd0: begin res = q << 1; c = q[31]; end
                    2'd1: begin res = (q << 1) | cin; c = q[31]; end
                    2'd2: begin res = q >> 1; c = q[0]; end
                    default: begin res = (q >> 1) | (32'(cin) << 31); c = q[0]; end
                endcase
            end else begin
                tag = "R10";
                res = op[5] ? q - 1 : q + 1;
            end
        end else if (op[2:0] == 3'b110 && op[7:5] != 3'd4 && op[7:5] != 3'd5) begin
            wr_m = 1; tag = "R11";
            case (op[7:5])
                3'd0: begin res = m << 1; c = m[31]; fm = 4'b1110; end
                3'd1: begin res = (m << 1) | cin; c = m[31]; fm = 4'b1110; end
                3'd2: begin res = m >> 1; c = m[0]; fm = 4'b1110; end
                3'd3: begin res = (m >> 1) | (32'(cin) << 31); c = m[0]; fm = 4'b1110; end
                3'd6: res = m - 1;
                default: res = m + 1;
            endcase
        end else begin
            case (op[7:5])
                3'd0: begin res = q | m; wr_r = 1; end
                3'd1: begin res = q & m; wr_r = 1; end
                3'd2: begin res = q ^ m; wr_r = 1; end
                3'd3: begin
                    tag = "R4"; wr_r = 1; fm = 4'b1111;
                    us = longint'({32'h0, q}) + longint'({32'h0, m}) + longint'(cin);
                    ss = longint'($signed(q)) + longint'($signed(m)) + longint'(cin);
                    res = us[31:0]; c = us > 64'sh0FFFFFFFF;
                    v = ss > 64'sh7FFFFFFF || ss < -64'sh80000000;
                end
                3'd4: begin tag = "R8"; res = q; wr_m = 1; end
                3'd5: begin tag = "R7"; res = m; wr_r = 1; end
                3'd6: begin
                    tag = "R6"; fm = 4'b1110;
                    res = q - m; c = ({32'h0, q} >= {32'h0, m});
                end
                default: begin
                    tag = "R5"; wr_r = 1; fm = 4'b1111;
                    res = q - m - 32'(!cin);
                    c = longint'({32'h0, q}) >= longint'({32'h0, m}) + longint'(!cin);
                    ss = longint'($signed(q)) - longint'($signed(m)) - longint'(!cin);
                    v = ss > 64'sh7FFFFFFF || ss < -64'sh80000000;
                end
            endcase
        end
        bundle = {44'h0, 1'b1, (wr_r ? res : q), wr_r, (wr_m ? res : 32'h0), wr_m,
                  ({res[31], res == 32'h0, c, v} & fm), fm};
    endtask

    task automatic run_op(input logic [7:0] op, input logic [31:0] q, input logic [31:0] m,
                          input logic cin);
        logic [127:0] exp;
        string tag;
        @(negedge clk);
        opcode = op; {z_in, y_in, x_in, a_in} = q; mem_in = m; carry_in = cin; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        model(op, q, m, cin, exp, tag);
        check($sformatf("%s R12 op=%02h q=%h m=%h c=%0d", tag, op, q, m, cin),
              {44'h0, done, z_out, y_out, x_out, a_out, reg_we, mem_out, mem_we,
               flag_n, flag_z, flag_c, flag_v, flag_we}, exp);
    endtask

    logic [31:0] pat [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                             32'h7FFF_FFFF, 32'h0000_0001, 32'h1234_5678};

    initial begin
        #(20 * 199000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        op_valid = 1'b1; opcode = 8'hA5; mem_in = 32'hFFFF_FFFF; a_in = 8'hFF;
        @(negedge clk);
        // R13: outputs cleared during reset even with op_valid high
        check("R13 reset", {44'h0, done, z_out, y_out, x_out, a_out, reg_we, mem_out,
              mem_we, flag_n, flag_z, flag_c, flag_v, flag_we}, 128'h0);
        op_valid = 1'b0; a_in = 8'h00;
        rst_n = 1'b1;

        // R1: load byte order
        run_op(8'hA5, 32'h0, 32'h4433_2211, 1'b0);
        check("R1 lanes", {96'h0, a_out, x_out, y_out, z_out}, {96'h0, 32'h1122_3344});
        // R1: store reads lanes in the same order
        run_op(8'h85, 32'hDDCC_BBAA, 32'h0, 1'b0);
        check("R1 store order", {96'h0, mem_out}, {96'h0, 32'hDDCC_BBAA});

        // R2: idle cycle after an operation
        @(negedge clk);
        check("R2 idle", {121'h0, done, reg_we, mem_we, flag_we}, 128'h0);
        check("R2 idle mem", {96'h0, mem_out}, 128'h0);

        // R3..R12: sweep of every opcode over boundary operand pairs
        for (int op = 0; op < 256; op++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 2; c++)
                        run_op(8'(op), pat[i], pat[j], 1'(c));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule